// File: doc/BRIEF.md
# Row-Batching DRAM Request Scheduler

This block stands in front of a single DRAM partition and gathers requests from several independent traffic sources into a small pool. It does not open a row when the first request for that row arrives. It waits until a batch of requests for the same bank and row has built up, or until one pending request has waited for the maximum allowed time. It then activates that row and issues every pending column access to it at the column spacing. After the last column access it precharges the bank. This gives up some latency to keep the data bus busy with column traffic, which first-come first-served service would not do.

Requests arrive as byte addresses with a write flag, under a valid/ready handshake. Counting from bit 0, the address holds a burst offset, then the partition-select bits, then the column, then the bank, then the row. The partition bits sit just above the burst offset so that consecutive bursts spread across partitions. Routing to this partition is done upstream, so this block drops both the offset and the partition bits. The command output carries the operation, the bank, the row and the column. The DRAM side always accepts a command.

Top module: `rb_row_batch_sched`

## Requirements
- R1: After reset no command is issued and `inReady` is 1.
- R2: The column is taken from bits `[OFF_W+PART_W +: COL_W]` of `inAddr`, the bank from the next `BANK_W` bits and the row from the `ROW_W` bits above those. The burst offset and partition bits have no effect on any command.
- R3: When the pool holds `BATCH` requests with the same bank and row and no row is open, an ACTIVATE for that bank and row appears in the cycle right after the edge that accepts the last of them.
- R4: A request that is not part of a full batch triggers an ACTIVATE of its row exactly `MAX_WAIT` cycles after its acceptance edge, provided no row is open at that time.
- R5: While no request has reached either the batch count or the wait limit, no command is issued.
- R6: The first column command after an ACTIVATE comes exactly `T_RCD` cycles after it.
- R7: Each pending request for the open row gets exactly one column command carrying its column, with consecutive column commands exactly `T_CCD` cycles apart. The operation codes are ACTIVATE=0, READ=1, WRITE=2 and PRECHARGE=3. A request with the write flag set gets WRITE and one with it clear gets READ.
- R8: A PRECHARGE to the open bank follows the last column command by `T_CCD` cycles. No ACTIVATE is issued while a row is open.
- R9: Column commands only go to the open bank and row. Pending requests to other rows of the same bank stay in the pool.
- R10: When all `DEPTH` pool slots are occupied, `inReady` is 0. It returns to 1 once the requests have been served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | A pool slot is free |
| inAddr | input | ADDR_W | Request byte address |
| inWrite | input | 1 | 1 = write, 0 = read |
| cmdValid | output | 1 | Command valid this cycle |
| cmdOp | output | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmdBank | output | BANK_W | Target bank |
| cmdRow | output | ROW_W | Target row |
| cmdCol | output | COL_W | Column for READ/WRITE |

## Verification
The bench builds the block with a four-slot pool, a batch count of 3, a wait limit of 40 cycles, `T_RCD`=20 and `T_CCD`=2. With these values a full batch, a lone timed-out request and a full pool can each be set up with only a few requests. It sweeps all four banks with mixed read and write batches and varying partition bits. It also mixes a competing row into the same bank, so that one batch drains while another request ages. From its own record of acceptance edges the bench computes the exact cycle of every ACTIVATE, column command and PRECHARGE.

// File: rtl/rb_sched_pkg.sv
package rb_sched_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic latchTarget;  // capture chosen bank/row as the open row
    logic popHit;       // retire the pool entry just served
  } ctrl_strobe_t;
endpackage

// File: rtl/rb_datapath.sv
module rb_datapath
  import rb_sched_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int BATCH    = 4,
  parameter int MAX_WAIT = 64,
  parameter int OFF_W    = 3,
  parameter int PART_W   = 2,
  parameter int COL_W    = 7,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 14,
  localparam int ADDR_W  = OFF_W + PART_W + COL_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  output logic              inReady,
  input  ctrl_strobe_t      strobe,
  output logic              candValid,
  output logic [BANK_W-1:0] candBank,
  output logic [ROW_W-1:0]  candRow,
  output logic              hitValid,
  output logic [COL_W-1:0]  hitCol,
  output logic              hitWrite,
  output logic [BANK_W-1:0] openBank,
  output logic [ROW_W-1:0]  openRow
);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int AGE_W   = $clog2(MAX_WAIT + 1);
  localparam int COL_LSB = OFF_W + PART_W;
  localparam int BNK_LSB = COL_LSB + COL_W;
  localparam int ROW_LSB = BNK_LSB + BANK_W;

  logic [DEPTH-1:0]  slotVld;
  logic [BANK_W-1:0] slotBank [DEPTH];
  logic [ROW_W-1:0]  slotRow  [DEPTH];
  logic [COL_W-1:0]  slotCol  [DEPTH];
  logic              slotWe   [DEPTH];
  logic [AGE_W-1:0]  slotAge  [DEPTH];
  logic [CNT_W-1:0]  rowCnt   [DEPTH];

  logic [IDX_W-1:0] freeIdx, hitIdx, agedIdx, fullIdx, candIdx;
  logic anyAged, anyFull;
  logic accept;

  assign inReady = ~&slotVld;
  assign accept  = inValid && inReady;

  // pending-request count per slot's bank/row
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rowCnt[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (slotVld[j] && slotBank[j] == slotBank[i] && slotRow[j] == slotRow[i])
          rowCnt[i] = rowCnt[i] + CNT_W'(1);
    end
  end

  // lowest-index searches: free slot, aged entry, full batch, open-row hit
  always_comb begin
    freeIdx = '0; agedIdx = '0; fullIdx = '0; hitIdx = '0;
    anyAged = 1'b0; anyFull = 1'b0; hitValid = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slotVld[i]) freeIdx = IDX_W'(i);
      if (slotVld[i] && slotAge[i] == AGE_W'(MAX_WAIT)) begin
        agedIdx = IDX_W'(i); anyAged = 1'b1;
      end
      if (slotVld[i] && rowCnt[i] >= CNT_W'(BATCH)) begin
        fullIdx = IDX_W'(i); anyFull = 1'b1;
      end
      if (slotVld[i] && slotBank[i] == openBank && slotRow[i] == openRow) begin
        hitIdx = IDX_W'(i); hitValid = 1'b1;
      end
    end
  end

  assign candIdx   = anyAged ? agedIdx : fullIdx;
  assign candValid = anyAged || anyFull;
  assign candBank  = slotBank[candIdx];
  assign candRow   = slotRow[candIdx];
  assign hitCol    = slotCol[hitIdx];
  assign hitWrite  = slotWe[hitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld  <= '0;
      openBank <= '0;
      openRow  <= '0;
    end else begin
      if (strobe.popHit) slotVld[hitIdx] <= 1'b0;
      if (accept) slotVld[freeIdx] <= 1'b1;
      if (strobe.latchTarget) begin
        openBank <= candBank;
        openRow  <= candRow;
      end
    end
  end

  // payload and age need no reset: every use is gated by slotVld
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (slotVld[i] && slotAge[i] != AGE_W'(MAX_WAIT))
        slotAge[i] <= slotAge[i] + AGE_W'(1);
    if (accept) begin
      slotBank[freeIdx] <= inAddr[BNK_LSB +: BANK_W];
      slotRow[freeIdx]  <= inAddr[ROW_LSB +: ROW_W];
      slotCol[freeIdx]  <= inAddr[COL_LSB +: COL_W];
      slotWe[freeIdx]   <= inWrite;
      slotAge[freeIdx]  <= '0;
    end
  end
endmodule

// File: rtl/rb_control.sv
module rb_control
  import rb_sched_pkg::*;
#(
  parameter int T_RCD = 20,
  parameter int T_CCD = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         candValid,
  input  logic         hitValid,
  input  logic         hitWrite,
  output ctrl_strobe_t strobe,
  output logic         cmdValid,
  output cmd_op_e      cmdOp
);
  localparam int TMR_W = $clog2((T_RCD > T_CCD ? T_RCD : T_CCD) + 1);

  typedef enum logic {ST_IDLE, ST_OPEN} state_e;
  state_e state, stateNxt;
  logic [TMR_W-1:0] gapTimer;

  always_comb begin
    strobe   = '0;
    cmdValid = 1'b0;
    cmdOp    = OP_ACT;
    stateNxt = state;
    case (state)
      ST_IDLE: if (candValid) begin
        cmdValid           = 1'b1;
        strobe.latchTarget = 1'b1;
        stateNxt           = ST_OPEN;
      end
      ST_OPEN: if (gapTimer == '0) begin
        cmdValid = 1'b1;
        if (hitValid) begin
          cmdOp         = hitWrite ? OP_WR : OP_RD;
          strobe.popHit = 1'b1;
        end else begin
          cmdOp    = OP_PRE;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapTimer <= '0;
    end else begin
      state <= stateNxt;
      if (strobe.latchTarget)  gapTimer <= TMR_W'(T_RCD - 1);
      else if (strobe.popHit)  gapTimer <= TMR_W'(T_CCD - 1);
      else if (gapTimer != '0) gapTimer <= gapTimer - TMR_W'(1);
    end
  end
endmodule

// File: rtl/rb_row_batch_sched.sv
module rb_row_batch_sched
  import rb_sched_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int BATCH    = 4,
  parameter int MAX_WAIT = 64,
  parameter int T_RCD    = 20,
  parameter int T_CCD    = 2,
  parameter int OFF_W    = 3,
  parameter int PART_W   = 2,
  parameter int COL_W    = 7,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 14,
  localparam int ADDR_W  = OFF_W + PART_W + COL_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol
);
  ctrl_strobe_t      strobe;
  cmd_op_e           opSel;
  logic              candValid, hitValid, hitWrite;
  logic [BANK_W-1:0] candBank, openBank;
  logic [ROW_W-1:0]  candRow, openRow;

  rb_datapath #(
    .DEPTH(DEPTH), .BATCH(BATCH), .MAX_WAIT(MAX_WAIT), .OFF_W(OFF_W),
    .PART_W(PART_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .inWrite(inWrite), .inReady(inReady), .strobe(strobe),
    .candValid(candValid), .candBank(candBank), .candRow(candRow),
    .hitValid(hitValid), .hitCol(cmdCol), .hitWrite(hitWrite),
    .openBank(openBank), .openRow(openRow)
  );

  rb_control #(.T_RCD(T_RCD), .T_CCD(T_CCD)) ctl_i (
    .clk(clk), .rstN(rstN), .candValid(candValid), .hitValid(hitValid),
    .hitWrite(hitWrite), .strobe(strobe), .cmdValid(cmdValid), .cmdOp(opSel)
  );

  assign cmdOp   = opSel;
  assign cmdBank = (opSel == OP_ACT) ? candBank : openBank;
  assign cmdRow  = (opSel == OP_ACT) ? candRow  : openRow;
endmodule

// File: rtl/rb_row_batch_sched_chk.sv
module rb_row_batch_sched_chk #(
  parameter int T_RCD  = 20,
  parameter int T_CCD  = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ROW_W-1:0]  cmdRow
);
  logic [15:0]       sinceAct, sinceCol;
  logic              isOpen;
  logic [BANK_W-1:0] actBank;
  logic [ROW_W-1:0]  actRow;
  logic              isAct, isCol, isPre;

  assign isAct = cmdValid && cmdOp == 2'd0;
  assign isCol = cmdValid && (cmdOp == 2'd1 || cmdOp == 2'd2);
  assign isPre = cmdValid && cmdOp == 2'd3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= '1; sinceCol <= '1; isOpen <= 1'b0;
      actBank <= '0; actRow <= '0;
    end else begin
      sinceAct <= isAct ? 16'd1 : (sinceAct == '1 ? sinceAct : sinceAct + 16'd1);
      sinceCol <= isCol ? 16'd1 : (isAct ? '1 :
                  (sinceCol == '1 ? sinceCol : sinceCol + 16'd1));
      if (isAct) begin
        isOpen <= 1'b1; actBank <= cmdBank; actRow <= cmdRow;
      end else if (isPre) isOpen <= 1'b0;
    end
  end

  assert_rcd_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> sinceAct >= 16'(T_RCD));
  assert_ccd_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> sinceCol >= 16'(T_CCD));
  assert_col_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> (isOpen && cmdBank == actBank && cmdRow == actRow));
  assert_act_closed_R8: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> !isOpen);
  assert_pre_open_R8: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (isOpen && cmdBank == actBank));
endmodule

bind rb_row_batch_sched rb_row_batch_sched_chk #(
  .T_RCD(T_RCD), .T_CCD(T_CCD), .BANK_W(BANK_W), .ROW_W(ROW_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdBank(cmdBank), .cmdRow(cmdRow)
);

// File: tb/rb_row_batch_sched_tb.sv
module rb_row_batch_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, BATCH = 3, MAX_WAIT = 40, T_RCD = 20, T_CCD = 2;
  localparam int OFF_W = 3, PART_W = 2, COL_W = 7, BANK_W = 2, ROW_W = 14;
  localparam int ADDR_W = OFF_W + PART_W + COL_W + BANK_W + ROW_W;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inWrite = 1'b0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic inReady, cmdValid;
  logic [1:0] cmdOp;
  logic [BANK_W-1:0] cmdBank;
  logic [ROW_W-1:0] cmdRow;
  logic [COL_W-1:0] cmdCol;

  rb_row_batch_sched #(
    .DEPTH(DEPTH), .BATCH(BATCH), .MAX_WAIT(MAX_WAIT), .T_RCD(T_RCD), .T_CCD(T_CCD),
    .OFF_W(OFF_W), .PART_W(PART_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .inWrite(inWrite), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int logN = 0;
  int logOp [256], logBank [256], logRow [256], logCol [256], logCyc [256];
  always @(negedge clk)
    if (rstN && cmdValid && logN < 256) begin
      logOp[logN] = int'(cmdOp); logBank[logN] = int'(cmdBank);
      logRow[logN] = int'(cmdRow); logCol[logN] = int'(cmdCol);
      logCyc[logN] = cyc; logN++;
    end

  int nChecks = 0, nErr = 0;

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns the cycle stamp of the accepting edge
  task automatic send(input int bank, input int row, input int col, input int we,
                      input int part, output int acc);
    inAddr = {ROW_W'(row), BANK_W'(bank), COL_W'(col), PART_W'(part), OFF_W'(part + 5)};
    inWrite = we[0];
    inValid = 1'b1;
    @(posedge clk); #1 acc = cyc;
    @(negedge clk); inValid = 1'b0;
  endtask

  task automatic verifyBatch(input int s, input int n, input int bank, input int row,
                             input int cols[4], input int wes[4], input int actCyc);
    bit used[4] = '{0, 0, 0, 0};
    int lastCyc;
    chkEq("R8 commands logged for batch", int'(logN >= s + n + 2), 1);
    if (logN < s + n + 2) return;
    chkEq("R3 R4 ACT op", logOp[s], 0);
    chkEq("R3 R4 ACT cycle", logCyc[s], actCyc);
    chkEq("R2 ACT bank", logBank[s], bank);
    chkEq("R2 ACT row", logRow[s], row);
    for (int k = 0; k < n; k++) begin
      int found = -1;
      chkEq("R6 R7 column cycle", logCyc[s+1+k], actCyc + T_RCD + k * T_CCD);
      chkEq("R9 column bank", logBank[s+1+k], bank);
      chkEq("R9 column row", logRow[s+1+k], row);
      for (int j = 0; j < n; j++)
        if (!used[j] && found < 0 && cols[j] == logCol[s+1+k]) found = j;
      chkEq("R2 R7 column value in batch", int'(found >= 0), 1);
      if (found >= 0) begin
        used[found] = 1'b1;
        chkEq("R7 column op", logOp[s+1+k], wes[found] != 0 ? 2 : 1);
      end
    end
    lastCyc = actCyc + T_RCD + (n - 1) * T_CCD;
    chkEq("R8 precharge op", logOp[s+n+1], 3);
    chkEq("R8 precharge cycle", logCyc[s+n+1], lastCyc + T_CCD);
    chkEq("R8 precharge bank", logBank[s+n+1], bank);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nErr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    int a0, a1, a2, a3, s;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    // R1: idle after reset
    chkEq("R1 no command after reset", logN, 0);
    chkEq("R1 ready after reset", int'(inReady), 1);

    // R3/R2/R7: full batch on every bank, mixed ops, varying partition bits
    for (int b = 0; b < 4; b++) begin
      int row = 100 + b * 37;
      s = logN;
      send(b, row, b * 3 + 1, b & 1, b, a0);
      send(b, row, b * 3 + 2, (b >> 1) & 1, 3 - b, a1);
      chkEq("R5 no command below batch", logN, s);
      send(b, row, b * 3 + 40, 1, b ^ 1, a2);
      waitCyc(T_RCD + 3 * T_CCD + 5);
      verifyBatch(s, 3, b, row, '{b * 3 + 1, b * 3 + 2, b * 3 + 40, 0},
                  '{b & 1, (b >> 1) & 1, 1, 0}, a2);
    end

    // R4/R5: lone request activates on timeout
    s = logN;
    send(1, 5, 9, 1, 2, a0);
    waitCyc(MAX_WAIT - 1);
    chkEq("R5 no command before timeout", logN, s);
    waitCyc(T_RCD + T_CCD + 6);
    verifyBatch(s, 1, 1, 5, '{9, 0, 0, 0}, '{1, 0, 0, 0}, a0 + MAX_WAIT);

    // R9/R8: other row of same bank stays pending, then times out
    s = logN;
    send(2, 7, 1, 0, 0, a0);
    send(2, 7, 2, 1, 1, a1);
    send(2, 8, 3, 0, 2, a2);
    send(2, 7, 4, 0, 3, a3);
    waitCyc(MAX_WAIT + T_RCD + T_CCD + 8);
    verifyBatch(s, 3, 2, 7, '{1, 2, 4, 0}, '{0, 1, 0, 0}, a3);
    verifyBatch(s + 5, 1, 2, 8, '{3, 0, 0, 0}, '{0, 0, 0, 0}, a2 + MAX_WAIT);

    // R10: pool full drops ready; all served afterwards
    s = logN;
    for (int k = 0; k < DEPTH; k++) send(3, 20 + k, k, 0, k, a0);
    chkEq("R10 ready low when pool full", int'(inReady), 0);
    waitCyc(200);
    chkEq("R10 ready back after drain", int'(inReady), 1);
    chkEq("R10 R4 all rows served", logN - s, DEPTH * 3);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule